// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

The block sits on the host side of a single-bit serial flash bus and turns one erase request into the full command exchange with the flash. A request carries an erase kind (whole device, sector or subsector) and a 24-bit address. The sequencer first sends a write-enable command. It then reads the status register once to confirm that the write-enable latch is set. Next it sends the erase opcode for the chosen kind, followed by the address when that kind needs one. Finally it reads the status register over and over until the busy flag clears, and then it pulses `done`.

The serial clock comes from a divider of the system clock. The bus runs with the clock idle low. Outgoing bits change only while the serial clock is low, and incoming bits are captured on its rising edge. Chip select goes high as soon as the last bit of each frame has been sent, because the flash starts its self-timed erase on that edge. It then stays high for a minimum gap before the next frame. A poll-count limit supplied by the host bounds the wait for the erase to finish.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done`, `err_wel` and `err_timeout` are all 0.
- R2: Every accepted request first sends an 8-bit frame holding opcode 06h. This is followed by a 16-bit status-read frame: opcode 05h, then 8 clocks during which the status byte is read in.
- R3: Erase kind `req_type` = 2'b00 sends opcode C7h as a frame of exactly 8 bits, with no address.
- R4: `req_type` = 2'b01 sends D8h, and `req_type` 2'b10 or 2'b11 sends 20h. Each of these frames is 32 bits: the opcode, then all 24 bits of `req_addr` unchanged, most significant bit first.
- R5: `spi_sclk` is 0 whenever `spi_cs_n` is 1. `spi_mosi` never changes while chip select is low and `spi_sclk` is high. Bits are sent MSB first.
- R6: Between frames, `spi_cs_n` stays high for at least two serial clock periods (4·CLK_DIV system cycles). It rises after the last bit of a frame, so the number of rising clock edges in a frame equals its bit count.
- R7: If status bit 1 (write-enable latch) reads 0 in the check after write enable, no erase frame is sent. The sequence ends with `done` and `err_wel` = 1.
- R8: After the erase frame, status-read frames repeat until status bit 0 (write in progress) reads 0. The sequence then ends with `done` = 1 and both error flags 0.
- R9: If `poll_limit` status reads in a row all show bit 0 = 1, the sequence ends with `done` and `err_timeout` = 1 (a limit of 0 acts as 1). If the read that reaches the limit shows bit 0 = 0, the result is success.
- R10: `busy` is 1 from the cycle after a request is accepted until `done`. `done` is a one-cycle pulse with `busy` 0, and the error flags hold until the next request. A `req_valid` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an erase sequence (taken only while idle) |
| req_type | input | 2 | 00 whole device, 01 sector, 1x subsector |
| req_addr | input | 24 | Any address inside the target region |
| poll_limit | input | POLL_W | Maximum number of status reads after the erase |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err_wel | output | 1 | Write-enable latch was not set |
| err_timeout | output | 1 | Poll limit reached while still busy |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
The poll-limit decision and the busy-flag decision can fall on the same status read. This happens when the read that reaches `poll_limit` is also the first one to show bit 0 cleared. The bench builds this case with a behavioural flash whose erase stays busy for exactly `poll_limit - 1` reads. It expects success with no timeout flag and exactly `poll_limit` status reads after the erase frame. A neighbouring vector keeps the erase busy for `poll_limit` reads and must produce a timeout.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_BULK   = 8'hC7;
  localparam logic [7:0] OP_SECTOR = 8'hD8;
  localparam logic [7:0] OP_SUBSEC = 8'h20;

  localparam int FRAME_W = 32;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WREN, SQ_WELCHK, SQ_ERASE, SQ_POLL
  } seq_state_t;

  typedef enum logic [2:0] {
    SH_IDLE, SH_LO, SH_HI, SH_TAIL, SH_GAP
  } shift_state_t;

endpackage

// File: rtl/fe_tick_gen.sv
module fe_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fe_shifter.sv
module fe_shifter
  import flash_erase_pkg::*;
#(
  parameter int DIV       = 2,
  parameter int GAP_TICKS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [5:0]         nbits,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [7:0]         rx_byte,
  output logic               done
);
  localparam int GW      = $clog2(GAP_TICKS) + 1;
  localparam int GAP_SYS = GAP_TICKS * DIV;
  localparam int HW      = $clog2(GAP_SYS + 1) + 1;

  shift_state_t       st;
  logic [FRAME_W-1:0] sr;
  logic [5:0]         bitcnt, last;
  logic [GW-1:0]      gcnt;
  logic               tick;

  fe_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst),
    .restart(start && st == SH_IDLE),
    .run(st != SH_IDLE),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SH_IDLE; cs_n <= 1'b1; sclk <= 1'b0; mosi <= 1'b0;
      done <= 1'b0; sr <= '0; bitcnt <= '0; last <= '0; gcnt <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SH_IDLE: if (start) begin
          sr     <= tx_word;
          last   <= nbits - 6'd1;
          bitcnt <= '0;
          cs_n   <= 1'b0;
          mosi   <= tx_word[FRAME_W-1];
          st     <= SH_LO;
        end
        SH_LO: if (tick) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
          st      <= SH_HI;
        end
        SH_HI: if (tick) begin
          sclk <= 1'b0;
          if (bitcnt == last) begin
            st <= SH_TAIL;
          end else begin
            bitcnt <= bitcnt + 6'd1;
            sr     <= sr << 1;
            mosi   <= sr[FRAME_W-2];
            st     <= SH_LO;
          end
        end
        SH_TAIL: if (tick) begin
          cs_n <= 1'b1;
          mosi <= 1'b0;
          gcnt <= '0;
          st   <= SH_GAP;
        end
        SH_GAP: if (tick) begin
          if (gcnt == GW'(GAP_TICKS - 1)) begin
            st   <= SH_IDLE;
            done <= 1'b1;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  // Chip-select high time, saturating, used only by the gap check below.
  logic [HW-1:0] cs_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)                         cs_hi_cnt <= HW'(GAP_SYS);
    else if (!cs_n)                  cs_hi_cnt <= '0;
    else if (cs_hi_cnt < HW'(GAP_SYS)) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R5

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk) |-> $stable(mosi)); // R5

  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (cs_hi_cnt >= HW'(GAP_SYS))); // R6
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int CS_GAP_CLKS = 2,
  parameter int POLL_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic [23:0]       req_addr,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic              err_wel,
  output logic              err_timeout,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int GAP_TICKS = 2 * CS_GAP_CLKS;

  seq_state_t         st;
  logic [1:0]         etype;
  logic [23:0]        eaddr;
  logic [POLL_W-1:0]  pollcnt;
  logic               sh_start, sh_done;
  logic [FRAME_W-1:0] sh_word;
  logic [5:0]         sh_bits;
  logic [7:0]         sh_rx;

  fe_shifter #(.DIV(CLK_DIV), .GAP_TICKS(GAP_TICKS)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx_word(sh_word),
    .nbits(sh_bits), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .miso(spi_miso), .rx_byte(sh_rx), .done(sh_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; busy <= 1'b0; done <= 1'b0; err_wel <= 1'b0;
      err_timeout <= 1'b0; etype <= '0; eaddr <= '0; pollcnt <= '0;
      sh_start <= 1'b0; sh_word <= '0; sh_bits <= '0;
    end else begin
      done     <= 1'b0;
      sh_start <= 1'b0;
      case (st)
        SQ_IDLE: if (req_valid) begin
          etype <= req_type; eaddr <= req_addr;
          err_wel <= 1'b0; err_timeout <= 1'b0; busy <= 1'b1;
          sh_word <= {OP_WREN, 24'h0}; sh_bits <= 6'd8; sh_start <= 1'b1;
          st <= SQ_WREN;
        end
        SQ_WREN: if (sh_done) begin
          sh_word <= {OP_RDSR, 24'h0}; sh_bits <= 6'd16; sh_start <= 1'b1;
          st <= SQ_WELCHK;
        end
        SQ_WELCHK: if (sh_done) begin
          if (!sh_rx[1]) begin
            err_wel <= 1'b1; done <= 1'b1; busy <= 1'b0; st <= SQ_IDLE;
          end else begin
            case (etype)
              2'b00:   begin sh_word <= {OP_BULK, 24'h0};  sh_bits <= 6'd8;  end
              2'b01:   begin sh_word <= {OP_SECTOR, eaddr}; sh_bits <= 6'd32; end
              default: begin sh_word <= {OP_SUBSEC, eaddr}; sh_bits <= 6'd32; end
            endcase
            sh_start <= 1'b1;
            st <= SQ_ERASE;
          end
        end
        SQ_ERASE: if (sh_done) begin
          sh_word <= {OP_RDSR, 24'h0}; sh_bits <= 6'd16; sh_start <= 1'b1;
          pollcnt <= POLL_W'(1);
          st <= SQ_POLL;
        end
        SQ_POLL: if (sh_done) begin
          if (!sh_rx[0]) begin
            done <= 1'b1; busy <= 1'b0; st <= SQ_IDLE;
          end else if (pollcnt >= poll_limit) begin
            err_timeout <= 1'b1; done <= 1'b1; busy <= 1'b0; st <= SQ_IDLE;
          end else begin
            pollcnt  <= pollcnt + 1'b1;
            sh_start <= 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_POLL && poll_limit != '0) |-> (pollcnt <= poll_limit)); // R9

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n); // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(eaddr) && $stable(etype))); // R10
endmodule

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
  localparam int DIV = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic [23:0] req_addr = '0;
  logic [7:0] poll_limit = '0;
  logic busy, done, err_wel, err_timeout, spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.CLK_DIV(DIV), .CS_GAP_CLKS(2), .POLL_W(8)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .poll_limit(poll_limit), .busy(busy), .done(done),
    .err_wel(err_wel), .err_timeout(err_timeout), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_tests = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural flash
  bit rec_en = 0;
  bit cfg_wel_ok = 1;
  int cfg_busy = 0;
  bit m_wel = 0;
  int m_busy = 0;
  logic [31:0] f_sh;
  int f_bits;
  logic [7:0] f_op;
  int n_fr = 0;
  logic [7:0] fr_op [32];
  int fr_bits [32];
  logic [23:0] fr_addr [32];

  always @(negedge spi_cs_n) begin f_bits = 0; f_sh = '0; end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    f_sh = {f_sh[30:0], spi_mosi};
    f_bits++;
    if (f_bits == 8) f_op = f_sh[7:0];
  end
  always @(negedge spi_sclk) if (!spi_cs_n && f_op == 8'h05 && f_bits >= 8 && f_bits < 16) begin
    logic [7:0] stv;
    stv = {6'b0, m_wel, (m_busy > 0)};
    spi_miso = stv[15 - f_bits];
  end
  always @(posedge spi_cs_n) if (rec_en) begin
    if (n_fr < 32) begin
      fr_op[n_fr] = f_op; fr_bits[n_fr] = f_bits; fr_addr[n_fr] = f_sh[23:0];
    end
    n_fr++;
    spi_miso = 1'b0;
    if (f_op == 8'h06 && cfg_wel_ok) m_wel = 1;
    if ((f_op == 8'hC7 || f_op == 8'hD8 || f_op == 8'h20) && m_wel) begin
      m_busy = cfg_busy;
      if (cfg_busy == 0) m_wel = 0;
    end
    if (f_op == 8'h05 && f_bits == 16 && m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) m_wel = 0;
    end
  end

  // Bus-level monitors sampled away from the clock edge
  int mosi_viol = 0, cs_hi = 1000, cs_min = 1000;
  logic prev_mosi = 1'b0;
  always @(negedge clk) if (rec_en) begin
    if (!spi_cs_n && spi_sclk && spi_mosi !== prev_mosi) mosi_viol++;
    if (spi_cs_n && spi_sclk) mosi_viol++;
    if (spi_cs_n) cs_hi++;
    else begin
      if (cs_hi > 0 && cs_hi < cs_min) cs_min = cs_hi;
      cs_hi = 0;
    end
    prev_mosi = spi_mosi;
  end

  typedef struct packed {
    logic [1:0]  typ;
    logic [23:0] addr;
    logic        wel_ok;
    logic [7:0]  bsy;
    logic [7:0]  lim;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 24'h000000, 1'b1, 8'd3, 8'd10},
    '{2'd1, 24'h123456, 1'b1, 8'd0, 8'd5},
    '{2'd2, 24'hFEDCBA, 1'b1, 8'd2, 8'd5},
    '{2'd3, 24'h000FFF, 1'b1, 8'd1, 8'd5},
    '{2'd1, 24'hABCDEF, 1'b0, 8'd2, 8'd5},
    '{2'd2, 24'h800001, 1'b1, 8'd6, 8'd4},
    '{2'd0, 24'h000000, 1'b1, 8'd4, 8'd5},
    '{2'd1, 24'h5A5A5A, 1'b1, 8'd5, 8'd5},
    '{2'd2, 24'h010203, 1'b1, 8'd2, 8'd0}
  };

  bit seen_done;
  task automatic run_req(input logic [1:0] t, input logic [23:0] a, input logic [7:0] l,
                         input bit inject);
    seen_done = 0;
    @(negedge clk);
    req_valid = 1; req_type = t; req_addr = a; poll_limit = l;
    @(negedge clk);
    req_valid = 0;
    check(busy === 1'b1, "R10 busy after accept", busy, 1);
    for (int c = 0; c < 20000; c++) begin
      if (inject && c == 30) begin req_valid = 1; req_type = 2'd0; req_addr = 24'h777777; end
      if (inject && c == 31) req_valid = 0;
      @(negedge clk);
      if (done) begin seen_done = 1; break; end
    end
    check(seen_done, "R10 done reached", seen_done, 1);
    check(busy === 1'b0, "R10 busy low with done", busy, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(spi_cs_n === 1'b1, "R1 cs_n reset", spi_cs_n, 1);
    check(spi_sclk === 1'b0, "R1 sclk reset", spi_sclk, 0);
    check({busy, done, err_wel, err_timeout} === 4'b0, "R1 status reset",
          {busy, done, err_wel, err_timeout}, 0);
    rec_en = 1;

    for (int v = 0; v < 9; v++) begin
      int lim1, expolls, exfr;
      bit exto;
      logic [7:0] exop;
      int exbits;
      lim1 = (VECS[v].lim == 0) ? 1 : int'(VECS[v].lim);
      exto = VECS[v].wel_ok && (int'(VECS[v].bsy) >= lim1);
      expolls = (int'(VECS[v].bsy) < lim1) ? int'(VECS[v].bsy) + 1 : lim1;
      exfr = VECS[v].wel_ok ? 3 + expolls : 2;
      exop = (VECS[v].typ == 2'd0) ? 8'hC7 : (VECS[v].typ == 2'd1) ? 8'hD8 : 8'h20;
      exbits = (VECS[v].typ == 2'd0) ? 8 : 32;
      cfg_wel_ok = VECS[v].wel_ok; cfg_busy = VECS[v].bsy;
      m_wel = 0; m_busy = 0; n_fr = 0;
      run_req(VECS[v].typ, VECS[v].addr, VECS[v].lim, 0);
      check(fr_op[0] == 8'h06 && fr_bits[0] == 8, "R2 write-enable frame", fr_op[0], 8'h06);
      check(fr_op[1] == 8'h05 && fr_bits[1] == 16, "R2 status frame", fr_op[1], 8'h05);
      check(n_fr == exfr, "R8 R9 frame count", n_fr, exfr);
      check(err_wel === !VECS[v].wel_ok, "R7 err_wel", err_wel, !VECS[v].wel_ok);
      check(err_timeout === exto, "R9 err_timeout", err_timeout, exto);
      if (VECS[v].wel_ok) begin
        check(fr_op[2] == exop, "R3 R4 erase opcode", fr_op[2], exop);
        check(fr_bits[2] == exbits, "R3 R4 erase length R6", fr_bits[2], exbits);
        if (exbits == 32)
          check(fr_addr[2] == VECS[v].addr, "R4 address", fr_addr[2], VECS[v].addr);
        for (int p = 3; p < exfr && p < 32; p++)
          check(fr_op[p] == 8'h05 && fr_bits[p] == 16, "R8 poll frame", fr_op[p], 8'h05);
      end
      repeat (3) @(negedge clk);
      check(err_wel === !VECS[v].wel_ok && err_timeout === exto, "R10 flags held",
            {err_wel, err_timeout}, {!VECS[v].wel_ok, exto});
    end

    // Request while busy is ignored (R10)
    cfg_wel_ok = 1; cfg_busy = 2; m_wel = 0; m_busy = 0; n_fr = 0;
    run_req(2'd1, 24'h3C3C3C, 8'd9, 1);
    check(n_fr == 6, "R10 frames with ignored request", n_fr, 6);
    check(fr_op[2] == 8'hD8 && fr_addr[2] == 24'h3C3C3C, "R10 erase kept first request",
          fr_addr[2], 24'h3C3C3C);
    repeat (300) @(negedge clk);
    check(n_fr == 6 && busy === 1'b0, "R10 no second sequence", n_fr, 6);

    check(mosi_viol == 0, "R5 mosi/sclk discipline", mosi_viol, 0);
    check(cs_min >= 4 * DIV, "R6 chip-select gap", cs_min, 4 * DIV);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule